// File: doc/BRIEF.md
# Tagged Transmit Byte Queue

This block is a 19-entry byte queue that sits in front of a frame transmitter. Each stored byte carries two tag bits. One marks the last byte of a frame (end of packet). The other marks the point where the frame now being loaded is to be abandoned (abort). Software-side logic does not write the tags with the byte. It arms a tag with a one-cycle strobe, at any time up to and including the cycle of the byte write. The next byte written takes the tag, and the write disarms it. The transmitter pulls entries from the head through a valid/ready pop port.

Occupancy is tracked by a three-state machine: `Q_EMPTY`, `Q_PARTIAL` and `Q_FULL`. The transitions are:

- `Q_EMPTY` to `Q_PARTIAL` on a write.
- `Q_PARTIAL` to `Q_FULL` on a write without a pop when 18 entries are held.
- `Q_PARTIAL` to `Q_EMPTY` on a pop without a write when one entry is held.
- `Q_FULL` to `Q_PARTIAL` on a pop without a write.
- Any state to `Q_EMPTY` on flush.

In `Q_FULL`, a write with no pop does not stall and is not dropped. It replaces the newest stored entry, both data and tags. When a write and a pop arrive together in `Q_FULL`, the pop is taken first and the write then appends normally.

Top module: `tx_tag_queue`

## Requirements
- R1: After reset the queue is empty: count is 0, `empty` is 1, `full` is 0, `rd_valid` is 0, and neither tag is armed.
- R2: Bytes leave in the order they were written. `rd_valid` is 1 exactly when count is non-zero, and `rd_data` shows the oldest byte. A pop is taken when `rd_valid` and `rd_ready` are both 1.
- R3: `count` runs from 0 to 19. `empty` is 1 only at 0 and `full` is 1 only at 19. A lone write adds one, a lone pop removes one, and a write with a pop leaves `count` unchanged.
- R4: A pulse on `arm_eop`, in the cycle of a write or in any earlier cycle since the last write, sets bit `rd_eop` to 1 for that byte. An armed tag persists across idle cycles.
- R5: A write disarms the end-of-packet tag, so the byte written after a tagged byte has `rd_eop` 0 unless the tag is armed again.
- R6: `arm_abort` behaves like `arm_eop`: it is attached to the next byte as `rd_abort` = 1 and is disarmed by that write.
- R7: A write with no pop while `full` is 1 replaces the newest entry's data and both tags with the new byte and its tags. `count` stays at 19 and the older entries are untouched.
- R8: A write and a pop in the same cycle while `full` is 1 remove the oldest byte and append the new one. No entry is overwritten and `count` stays at 19.
- R9: `flush` empties the queue and disarms both tags in one cycle. A write, pop or arm strobe in the same cycle is ignored.
- R10: `rd_ready` while the queue is empty has no effect: `count` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write one byte this cycle |
| wr_data | input | 8 | Byte to write |
| arm_eop | input | 1 | Strobe arming the end-of-packet tag |
| arm_abort | input | 1 | Strobe arming the abort tag |
| flush | input | 1 | Empty the queue and disarm tags |
| rd_valid | output | 1 | Head entry present |
| rd_ready | input | 1 | Transmitter accepts the head entry |
| rd_data | output | 8 | Head byte |
| rd_eop | output | 1 | Head byte ends a packet |
| rd_abort | output | 1 | Head byte marks a frame abort |
| empty | output | 1 | No entries held |
| full | output | 1 | 19 entries held |
| count | output | 5 | Entries held |

## Verification
Every stimulus is accepted on one rising edge. `count`, `empty`, `full` and `rd_valid` change right after that edge. The head byte and its tags are a combinational read of storage, so they show the new head from the same edge on. A tag armed early becomes visible only when its byte reaches the head. The bench drives inputs just after a falling edge and advances a behavioural queue model in step. It compares all outputs at the next falling edge, one edge later, so every result is checked in the cycle it is due.

// File: rtl/tq_pkg.sv
package tq_pkg;

    typedef enum logic [1:0] {
        Q_EMPTY   = 2'd0,
        Q_PARTIAL = 2'd1,
        Q_FULL    = 2'd2
    } occ_state_e;

    typedef struct packed {
        logic eop;
        logic abort;
    } tag_t;

endpackage

// File: rtl/tq_arm.sv
module tq_arm
    import tq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic wr_en,
    input  logic arm_eop,
    input  logic arm_abort,
    output tag_t wr_tag,
    output tag_t armed
);

    tag_t armed_q;

    always_comb begin
        wr_tag.eop   = armed_q.eop   | arm_eop;
        wr_tag.abort = armed_q.abort | arm_abort;
        armed        = armed_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= '0;
        end else if (flush) begin
            armed_q <= '0;
        end else if (wr_en) begin
            armed_q <= '0;
        end else begin
            armed_q.eop   <= armed_q.eop   | arm_eop;
            armed_q.abort <= armed_q.abort | arm_abort;
        end
    end

endmodule

// File: rtl/tq_ctrl.sv
module tq_ctrl
    import tq_pkg::*;
#(
    parameter int unsigned DEPTH = 19,
    parameter int unsigned PTR_W = $clog2(DEPTH),
    parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             wr_en,
    input  logic             rd_ready,
    output logic             slot_we,
    output logic [PTR_W-1:0] waddr,
    output logic [PTR_W-1:0] raddr,
    output logic [CNT_W-1:0] count,
    output logic             empty,
    output logic             full,
    output logic             rd_valid
);

    localparam logic [PTR_W-1:0] LAST_PTR  = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] NEAR_FULL = CNT_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

    occ_state_e       state_q, state_d;
    logic [CNT_W-1:0] count_q, count_d;
    logic [PTR_W-1:0] head_q, head_d;
    logic [PTR_W-1:0] tail_q, tail_d;
    logic             wr_act, pop_act, overwrite, append;
    logic [PTR_W-1:0] head_nx, tail_nx, tail_pv;

    always_comb begin
        wr_act    = wr_en && !flush;
        pop_act   = rd_ready && (state_q != Q_EMPTY) && !flush;
        overwrite = wr_act && (state_q == Q_FULL) && !pop_act;
        append    = wr_act && !overwrite;
        head_nx   = (head_q == LAST_PTR) ? '0 : head_q + PTR_W'(1);
        tail_nx   = (tail_q == LAST_PTR) ? '0 : tail_q + PTR_W'(1);
        tail_pv   = (tail_q == '0) ? LAST_PTR : tail_q - PTR_W'(1);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            Q_EMPTY: begin
                if (wr_act) state_d = Q_PARTIAL;
            end
            Q_PARTIAL: begin
                if (append && !pop_act && count_q == NEAR_FULL)
                    state_d = Q_FULL;
                else if (pop_act && !append && count_q == ONE)
                    state_d = Q_EMPTY;
            end
            Q_FULL: begin
                if (pop_act && !wr_act) state_d = Q_PARTIAL;
            end
            default: state_d = Q_EMPTY;
        endcase
        if (flush) state_d = Q_EMPTY;
    end

    // datapath next values
    always_comb begin
        count_d = count_q;
        head_d  = head_q;
        tail_d  = tail_q;
        if (flush) begin
            count_d = '0;
            head_d  = '0;
            tail_d  = '0;
        end else begin
            if (append && !pop_act) count_d = count_q + ONE;
            if (pop_act && !append) count_d = count_q - ONE;
            if (pop_act)            head_d  = head_nx;
            if (append)             tail_d  = tail_nx;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= Q_EMPTY;
            count_q <= '0;
            head_q  <= '0;
            tail_q  <= '0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
            head_q  <= head_d;
            tail_q  <= tail_d;
        end
    end

    // outputs
    always_comb begin
        empty    = (state_q == Q_EMPTY);
        full     = (state_q == Q_FULL);
        rd_valid = (state_q != Q_EMPTY);
        count    = count_q;
        raddr    = head_q;
        slot_we  = wr_act;
        waddr    = overwrite ? tail_pv : tail_q;
    end

endmodule

// File: rtl/tq_store.sv
module tq_store
    import tq_pkg::*;
#(
    parameter int unsigned DEPTH  = 19,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned PTR_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  tag_t              wtag,
    input  logic [PTR_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata,
    output tag_t              rtag
);

    logic [DATA_W-1:0] data_q [DEPTH];
    tag_t              tag_q  [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                data_q[i] <= '0;
                tag_q[i]  <= '0;
            end else if (we && waddr == PTR_W'(i)) begin
                data_q[i] <= wdata;
                tag_q[i]  <= wtag;
            end
        end
    end

    always_comb begin
        rdata = data_q[raddr];
        rtag  = tag_q[raddr];
    end

endmodule

// File: rtl/tx_tag_queue.sv
module tx_tag_queue
    import tq_pkg::*;
#(
    parameter int unsigned DEPTH  = 19,
    parameter int unsigned DATA_W = 8,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              arm_eop,
    input  logic              arm_abort,
    input  logic              flush,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_eop,
    output logic              rd_abort,
    output logic              empty,
    output logic              full,
    output logic [CNT_W-1:0]  count
);

    tag_t             wr_tag_w, armed_w, rd_tag_w;
    logic             slot_we_w;
    logic [PTR_W-1:0] waddr_w, raddr_w;

    tq_arm u_arm (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .wr_en     (wr_en),
        .arm_eop   (arm_eop),
        .arm_abort (arm_abort),
        .wr_tag    (wr_tag_w),
        .armed     (armed_w)
    );

    tq_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .wr_en    (wr_en),
        .rd_ready (rd_ready),
        .slot_we  (slot_we_w),
        .waddr    (waddr_w),
        .raddr    (raddr_w),
        .count    (count),
        .empty    (empty),
        .full     (full),
        .rd_valid (rd_valid)
    );

    tq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .PTR_W(PTR_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (slot_we_w),
        .waddr (waddr_w),
        .wdata (wr_data),
        .wtag  (wr_tag_w),
        .raddr (raddr_w),
        .rdata (rd_data),
        .rtag  (rd_tag_w)
    );

    always_comb begin
        rd_eop   = rd_tag_w.eop;
        rd_abort = rd_tag_w.abort;
    end

endmodule

// File: rtl/tq_checker.sv
module tq_checker #(
    parameter int unsigned DEPTH = 19,
    parameter int unsigned CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             flush,
    input logic             rd_ready,
    input logic             rd_valid,
    input logic             arm_eop,
    input logic             arm_abort,
    input logic             empty,
    input logic             full,
    input logic [CNT_W-1:0] count,
    input logic             armed_eop,
    input logic             armed_abort
);

    localparam logic [CNT_W-1:0] TOP = CNT_W'(DEPTH);

    p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= TOP);

    p_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (empty == (count == '0)) && (full == (count == TOP)));

    p_grow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !flush && !full && !(rd_ready && rd_valid))
        |=> count == $past(count) + CNT_W'(1));

    p_shrink_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ready && rd_valid && !wr_en && !flush)
        |=> count == $past(count) - CNT_W'(1));

    p_arm_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_eop && !wr_en && !flush) |=> armed_eop);

    p_eop_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !flush) |=> !armed_eop);

    p_abort_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !flush) |=> !armed_abort);

    p_abort_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_abort && !wr_en && !flush) |=> armed_abort);

    p_overwrite_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_ready && !flush) |=> full);

    p_swap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && rd_ready && !flush) |=> full);

    p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (empty && count == '0 && !armed_eop && !armed_abort));

    p_empty_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_ready && !wr_en && !flush) |=> empty);

endmodule

bind tx_tag_queue tq_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .flush       (flush),
    .rd_ready    (rd_ready),
    .rd_valid    (rd_valid),
    .arm_eop     (arm_eop),
    .arm_abort   (arm_abort),
    .empty       (empty),
    .full        (full),
    .count       (count),
    .armed_eop   (armed_w.eop),
    .armed_abort (armed_w.abort)
);

// File: tb/tx_tag_queue_tb_top.sv
module tx_tag_queue_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 19;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       arm_eop = 1'b0;
    logic       arm_abort = 1'b0;
    logic       flush = 1'b0;
    logic       rd_ready = 1'b0;
    logic       rd_valid, rd_eop, rd_abort, empty, full;
    logic [7:0] rd_data;
    logic [4:0] count;

    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;
    int  mq[$];
    bit  m_ae, m_aa;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tx_tag_queue dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .arm_eop(arm_eop), .arm_abort(arm_abort), .flush(flush),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .rd_eop(rd_eop), .rd_abort(rd_abort), .empty(empty), .full(full),
        .count(count)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic compare_all();
        int sz = mq.size();
        check("R3 count", int'(count), sz);
        check("R3 empty", int'(empty), int'(sz == 0));
        check("R3 full", int'(full), int'(sz == DEPTH));
        check("R2 rd_valid", int'(rd_valid), int'(sz != 0));
        if (sz != 0) begin
            check("R2 rd_data", int'(rd_data), mq[0] & 8'hFF);
            check("R4 rd_eop", int'(rd_eop), (mq[0] >> 9) & 1);
            check("R6 rd_abort", int'(rd_abort), (mq[0] >> 8) & 1);
        end
    endtask

    // drive one cycle, advance the model, compare at the next falling edge
    task automatic step(bit w, int d, bit ae, bit aa, bit fl, bit rdy);
        bit pop;
        int ent;
        wr_en = w; wr_data = 8'(d); arm_eop = ae; arm_abort = aa;
        flush = fl; rd_ready = rdy;
        if (fl) begin
            mq.delete();
            m_ae = 0; m_aa = 0;
        end else begin
            pop = rdy && (mq.size() > 0);
            if (w) begin
                ent = (int'(m_ae | ae) << 9) | (int'(m_aa | aa) << 8) | (d & 8'hFF);
                m_ae = 0; m_aa = 0;
                if (pop) void'(mq.pop_front());
                if (mq.size() == DEPTH) mq[DEPTH-1] = ent;
                else mq.push_back(ent);
            end else begin
                m_ae = m_ae | ae;
                m_aa = m_aa | aa;
                if (pop) void'(mq.pop_front());
            end
        end
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr(int d, bit ae = 0, bit aa = 0);
        step(1, d, ae, aa, 0, 0);
    endtask

    task automatic pop1();
        step(0, 0, 0, 0, 0, 1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R2 watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        m_ae = 0; m_aa = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 count", int'(count), 0);
        check("R1 rd_valid", int'(rd_valid), 0);
        check("R1 empty", int'(empty), 1);
        compare_all();

        // R4/R5: arm early, tag lands on next byte only
        step(0, 0, 1, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0);
        wr(8'h11);
        wr(8'h22);
        check("R4 eop on tagged byte", int'(rd_eop), 1);
        pop1();
        check("R5 eop cleared after write", int'(rd_eop), 0);
        check("R2 order", int'(rd_data), 8'h22);
        pop1();
        // R10: ready on empty
        pop1();
        check("R10 count stays 0", int'(count), 0);

        // R6: abort tag armed with the write
        wr(8'h33, 0, 1);
        wr(8'h44);
        check("R6 abort on tagged byte", int'(rd_abort), 1);
        pop1();
        check("R6 abort cleared after write", int'(rd_abort), 0);
        pop1();

        // R7: overwrite newest when full
        for (int i = 0; i < DEPTH; i++) wr(8'h50 + i);
        check("R3 full at 19", int'(full), 1);
        wr(8'hAA, 1, 0);
        check("R7 count held", int'(count), DEPTH);
        check("R7 head untouched", int'(rd_data), 8'h50);
        for (int i = 0; i < DEPTH - 1; i++) pop1();
        check("R7 newest replaced", int'(rd_data), 8'hAA);
        check("R7 tag replaced", int'(rd_eop), 1);
        pop1();

        // R8: write with pop while full
        for (int i = 0; i < DEPTH; i++) wr(8'h60 + i);
        step(1, 8'hBB, 0, 0, 0, 1);
        check("R8 count held", int'(count), DEPTH);
        check("R8 head advanced", int'(rd_data), 8'h61);
        for (int i = 0; i < DEPTH - 1; i++) pop1();
        check("R8 appended last", int'(rd_data), 8'hBB);
        pop1();

        // R9: flush with write and armed tag
        wr(8'h01);
        step(0, 0, 1, 1, 0, 0);
        step(1, 8'hCC, 1, 0, 1, 1);
        check("R9 empty after flush", int'(empty), 1);
        wr(8'hDD);
        check("R9 eop disarmed", int'(rd_eop), 0);
        check("R9 abort disarmed", int'(rd_abort), 0);
        pop1();

        // mixed traffic
        for (int n = 0; n < 3000; n++) begin
            step($urandom_range(0, 99) < 60, $urandom_range(0, 255),
                 $urandom_range(0, 99) < 15, $urandom_range(0, 99) < 10,
                 $urandom_range(0, 999) < 8, $urandom_range(0, 99) < 45);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule